// File: doc/BRIEF.md
# MEI Snoop Coherency State Controller

This block keeps a three-state coherency state (modified, exclusive, invalid) for a small, fully associative set of cache lines. Each line holds a full address tag and a state. A local requester presents loads and stores. The block decides whether each request hits. If it misses, it asks the bus for a read or a read-with-intent-to-modify into a way that the requester chooses. Before that way is refilled, any modified data in it is pushed out. The requester holds its request until it sees an acknowledge pulse.

The block also watches the system bus. A transaction is examined only when transfer start and the global attribute appear in the same clock. A hit is then handled according to the transfer type. The block may invalidate the line, downgrade it, push dirty data, discard dirty data, raise address retry and cancel a matching load reservation. While a push is in flight, the line change it will cause is held back until a push-done input arrives. All bus operations share one channel. A snoop that would need that channel while it is busy is retried and has no effect.

Top module: `mei_coherency_ctrl`

## Requirements
- R1: After reset every line is invalid. The states are encoded I=00, E=01, M=10, and line i appears at bits [2i+1:2i] of line_state. No bus request, retry, cancel or acknowledge is asserted.
- R2: A snoop is acted on only when snp_ts and snp_gbl are both high in the same cycle. Any other combination leaves every line state unchanged and raises neither retry, bus request nor cancel.
- R3: A load that hits a line in E or M is acknowledged one cycle later, with no bus request and no state change. A store hit acknowledges, moves an E line to M and leaves an M line in M.
- R4: A load miss issues one bus_req with bus_op=01 (read) and the request address. In the same cycle it raises set_entry_vld with set_entry equal to the chosen way. When bus_done arrives with bus_artry low, the line becomes E and the load is acknowledged. When bus_done arrives with bus_artry high, the read is issued again and the line stays I.
- R5: A store miss behaves like R4 but uses bus_op=10 (read-with-intent-to-modify), and the line ends in M.
- R6: A miss whose chosen way holds an M line first issues bus_op=11 (push) with the victim's address, without set_entry_vld. After push_done the victim becomes I, and the fill then proceeds as in R4 or R5.
- R7: A snooped cacheable read (type 8, atomic 9) or read-with-intent-to-modify (type 10, atomic 11) leaves I lines alone and turns E into I. For an M line it raises retry, issues a push, and moves the line to I once push_done arrives.
- R8: A snooped read (type 8 or 9) with snp_ci high leaves an E line in E with no bus request. For an M line it raises retry, pushes, and moves the line to E after push_done.
- R9: A snooped write-with-kill (type 7) forces a hitting E or M line to I at once, with no push and no retry.
- R10: A snooped kill-block (type 6) turns E into I. For an M line it pushes and then invalidates, and never raises retry.
- R11: A snooped write-with-flush (type 4, atomic 5) turns E into I. For an M line it raises retry, pushes and invalidates after push_done.
- R12: Snooped types 0 (sync), 1 (TLB invalidate), 2 (clean), 3 (flush) and 12 to 15 change no line and raise neither retry nor bus request.
- R13: A completed load with req_atomic high records a single reservation on its address. A qualified snoop of types 6 or 7 to that address, or one that invalidates that line, pulses resv_cancel for one cycle and clears the reservation. A later snoop to the same address then gives no pulse.
- R14: While a bus operation is outstanding, a qualified snoop that would need a push, or that would change the line currently being pushed, asserts retry and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present, held until req_ack |
| req_store | input | 1 | 1 = store, 0 = load |
| req_atomic | input | 1 | Load takes a reservation |
| req_addr | input | ADDR_W | Local line address |
| req_way | input | WAY_W | Way to refill on a miss |
| req_ack | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | One-cycle bus operation request |
| bus_op | output | 2 | 01 read, 10 read-with-intent-to-modify, 11 push |
| bus_addr | output | ADDR_W | Address of the bus operation |
| set_entry | output | WAY_W | Way being refilled |
| set_entry_vld | output | 1 | set_entry is meaningful (refill reads only) |
| bus_done | input | 1 | Own read finished this cycle |
| bus_artry | input | 1 | Address retry seen on own read |
| push_done | input | 1 | Outstanding push completed |
| snp_ts | input | 1 | Snooped transfer start |
| snp_gbl | input | 1 | Snooped global attribute |
| snp_tt | input | 4 | Snooped transfer type |
| snp_ci | input | 1 | Snooped transfer is caching-inhibited |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_artry | output | 1 | Address retry for the snooped transfer |
| resv_cancel | output | 1 | Reservation cancel pulse |
| line_state | output | 2*LINES | Packed state of all lines |

## Verification
Every output is registered, so all results appear exactly one clock edge after the inputs that cause them. This covers retry, cancel and push request for a snoop, the acknowledge for a hit, and the state after bus_done or push_done. The bench therefore drives each stimulus at a falling edge and checks at the next falling edge. A push adds one more step: its final state is checked one edge after push_done is driven. A miss with retry is followed edge by edge, with the reissued request expected on the edge that samples the retried bus_done.

// File: rtl/mei_coherency_ctrl.sv
module mei_coherency_ctrl #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  localparam int WAY_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_store,
  input  logic                 req_atomic,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [WAY_W-1:0]     req_way,
  output logic                 req_ack,
  output logic                 bus_req,
  output logic [1:0]           bus_op,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [WAY_W-1:0]     set_entry,
  output logic                 set_entry_vld,
  input  logic                 bus_done,
  input  logic                 bus_artry,
  input  logic                 push_done,
  input  logic                 snp_ts,
  input  logic                 snp_gbl,
  input  logic [3:0]           snp_tt,
  input  logic                 snp_ci,
  input  logic [ADDR_W-1:0]    snp_addr,
  output logic                 snp_artry,
  output logic                 resv_cancel,
  output logic [2*LINES-1:0]   line_state
);
  localparam logic [1:0] ST_I = 2'b00, ST_E = 2'b01, ST_M = 2'b10;
  localparam logic [1:0] OP_RD = 2'b01, OP_RWITM = 2'b10, OP_PUSH = 2'b11;

  typedef enum logic [1:0] {F_IDLE, F_FILL, F_SPUSH, F_CAST} fsm_t;

  logic [1:0]        st  [LINES];
  logic [ADDR_W-1:0] tag [LINES];
  fsm_t              fsm;
  logic [WAY_W-1:0]  pend_idx;
  logic [1:0]        pend_st;
  logic              fill_store, fill_atomic;
  logic              resv_v;
  logic [ADDR_W-1:0] resv_a;

  for (genvar g = 0; g < LINES; g++) begin : g_out
    assign line_state[2*g +: 2] = st[g];
    // R1
    legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n) st[g] != 2'b11);
  end

  wire qual    = snp_ts & snp_gbl;
  wire t_rd    = (snp_tt == 4'd8)  || (snp_tt == 4'd9);
  wire t_rwitm = (snp_tt == 4'd10) || (snp_tt == 4'd11);
  wire t_wwf   = (snp_tt == 4'd4)  || (snp_tt == 4'd5);
  wire t_kill  = (snp_tt == 4'd6);
  wire t_wwk   = (snp_tt == 4'd7);

  logic             s_hit, l_hit;
  logic [WAY_W-1:0] s_idx, l_idx;

  always_comb begin
    s_hit = 1'b0; s_idx = '0;
    l_hit = 1'b0; l_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!s_hit && st[i] != ST_I && tag[i] == snp_addr) begin
        s_hit = 1'b1; s_idx = WAY_W'(i);
      end
      if (!l_hit && st[i] != ST_I && tag[i] == req_addr) begin
        l_hit = 1'b1; l_idx = WAY_W'(i);
      end
    end
  end

  wire [1:0] hst = st[s_idx];
  logic [1:0] s_next;
  logic       s_push, s_rty;

  always_comb begin
    s_next = hst; s_push = 1'b0; s_rty = 1'b0;
    if (hst == ST_E) begin
      if ((t_rd && !snp_ci) || t_rwitm || t_wwf || t_kill || t_wwk) s_next = ST_I;
    end else if (hst == ST_M) begin
      if (t_wwk) s_next = ST_I;
      else if (t_rd && snp_ci) begin s_next = ST_E; s_push = 1'b1; s_rty = 1'b1; end
      else if (t_rd || t_rwitm || t_wwf) begin s_next = ST_I; s_push = 1'b1; s_rty = 1'b1; end
      else if (t_kill) begin s_next = ST_I; s_push = 1'b1; end
    end
  end

  wire pushing = (fsm == F_SPUSH) || (fsm == F_CAST);
  wire s_act   = qual && s_hit && (s_push || s_next != hst);
  wire s_block = s_act && (fsm != F_IDLE) && (s_push || (pushing && s_idx == pend_idx));
  wire s_apply = s_act && !s_block;
  wire cancel_d = qual && resv_v && (resv_a == snp_addr) && !s_block &&
                  (t_kill || t_wwk || (s_apply && s_next == ST_I));
  wire loc_go  = (fsm == F_IDLE) && req_valid && !req_ack && !qual;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st[i]  <= ST_I;
        tag[i] <= '0;
      end
      fsm <= F_IDLE; pend_idx <= '0; pend_st <= ST_I;
      fill_store <= 1'b0; fill_atomic <= 1'b0;
      resv_v <= 1'b0; resv_a <= '0;
      req_ack <= 1'b0; bus_req <= 1'b0; bus_op <= 2'b00; bus_addr <= '0;
      set_entry <= '0; set_entry_vld <= 1'b0; snp_artry <= 1'b0; resv_cancel <= 1'b0;
    end else begin
      req_ack <= 1'b0; bus_req <= 1'b0; bus_op <= 2'b00;
      set_entry <= '0; set_entry_vld <= 1'b0;
      snp_artry   <= qual && (s_block || (s_apply && s_rty));
      resv_cancel <= cancel_d;

      case (fsm)
        F_IDLE: if (loc_go) begin
          if (l_hit) begin
            req_ack <= 1'b1;
            if (req_store) st[l_idx] <= ST_M;
            else if (req_atomic) begin resv_v <= 1'b1; resv_a <= req_addr; end
          end else if (st[req_way] == ST_M) begin
            bus_req <= 1'b1; bus_op <= OP_PUSH; bus_addr <= tag[req_way];
            pend_idx <= req_way; pend_st <= ST_I; fsm <= F_CAST;
          end else begin
            tag[req_way] <= req_addr; st[req_way] <= ST_I;
            pend_idx <= req_way; fill_store <= req_store; fill_atomic <= req_atomic;
            bus_req <= 1'b1; bus_op <= req_store ? OP_RWITM : OP_RD; bus_addr <= req_addr;
            set_entry <= req_way; set_entry_vld <= 1'b1; fsm <= F_FILL;
          end
        end
        F_FILL: if (bus_done) begin
          if (bus_artry) begin
            bus_req <= 1'b1; bus_op <= fill_store ? OP_RWITM : OP_RD; bus_addr <= tag[pend_idx];
            set_entry <= pend_idx; set_entry_vld <= 1'b1;
          end else begin
            st[pend_idx] <= fill_store ? ST_M : ST_E;
            req_ack <= 1'b1; fsm <= F_IDLE;
            if (!fill_store && fill_atomic) begin resv_v <= 1'b1; resv_a <= tag[pend_idx]; end
          end
        end
        default: if (push_done) begin
          st[pend_idx] <= pend_st; fsm <= F_IDLE;
        end
      endcase

      if (s_apply) begin
        if (s_push) begin
          bus_req <= 1'b1; bus_op <= OP_PUSH; bus_addr <= snp_addr;
          pend_idx <= s_idx; pend_st <= s_next; fsm <= F_SPUSH;
        end else begin
          st[s_idx] <= s_next;
        end
      end
      if (cancel_d) resv_v <= 1'b0;
    end
  end

  // R2
  artry_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_artry |-> $past(snp_ts && snp_gbl));
  // R13
  cancel_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resv_cancel |-> $past(snp_ts && snp_gbl));
  // R3
  ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> ($past(req_valid) && !bus_req));
  // R4
  entry_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_entry_vld |-> (bus_req && (bus_op == OP_RD || bus_op == OP_RWITM)));
  // R6
  push_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_op == OP_PUSH) |-> (st[pend_idx] == ST_M));
  // R10
  kill_no_rty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_artry && $past(snp_tt == 4'd6)) |-> $past(fsm != F_IDLE));
endmodule

// File: tb/mei_coherency_ctrl_tb.sv
module mei_coherency_ctrl_tb_top;
  localparam int LINES = 4, ADDR_W = 8, WAY_W = 2;
  localparam logic [7:0] A = 8'h5A, B = 8'h33, C = 8'hC4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, req_atomic = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [WAY_W-1:0]  req_way = '0;
  logic req_ack, bus_req, set_entry_vld, snp_artry, resv_cancel;
  logic [1:0] bus_op;
  logic [ADDR_W-1:0] bus_addr;
  logic [WAY_W-1:0] set_entry;
  logic bus_done = 0, bus_artry = 0, push_done = 0;
  logic snp_ts = 0, snp_gbl = 0, snp_ci = 0;
  logic [3:0] snp_tt = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [2*LINES-1:0] line_state;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mei_coherency_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_atomic(req_atomic), .req_addr(req_addr), .req_way(req_way), .req_ack(req_ack),
    .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .set_entry(set_entry),
    .set_entry_vld(set_entry_vld), .bus_done(bus_done), .bus_artry(bus_artry),
    .push_done(push_done), .snp_ts(snp_ts), .snp_gbl(snp_gbl), .snp_tt(snp_tt),
    .snp_ci(snp_ci), .snp_addr(snp_addr), .snp_artry(snp_artry),
    .resv_cancel(resv_cancel), .line_state(line_state));

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int ls(input int w);
    return int'(line_state[2*w +: 2]);
  endfunction

  task automatic step;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 0; req_valid = 0; bus_done = 0; bus_artry = 0; push_done = 0;
    snp_ts = 0; snp_gbl = 0; snp_ci = 0;
    step; step; rst_n = 1; step;
  endtask

  task automatic fill(input logic [7:0] a, input int w, input bit store, input bit atomic);
    req_valid = 1; req_store = store; req_atomic = atomic; req_addr = a; req_way = w[1:0];
    step; bus_done = 1; bus_artry = 0;
    step; bus_done = 0; req_valid = 0; req_atomic = 0;
    step;
  endtask

  task automatic snoop(input int tt, input bit ci, input logic [7:0] a);
    snp_ts = 1; snp_gbl = 1; snp_tt = tt[3:0]; snp_ci = ci; snp_addr = a;
    step; snp_ts = 0; snp_gbl = 0;
  endtask

  function automatic void model(input int s, input int tt, input bit ci,
                                output int nx, output bit push, output bit rty);
    bit rd = (tt == 8 || tt == 9), rw = (tt == 10 || tt == 11);
    bit wf = (tt == 4 || tt == 5), kl = (tt == 6), wk = (tt == 7);
    nx = s; push = 0; rty = 0;
    if (s == 1) begin
      if ((rd && !ci) || rw || wf || kl || wk) nx = 0;
    end else if (s == 2) begin
      if (wk) nx = 0;
      else if (rd && ci) begin nx = 1; push = 1; rty = 1; end
      else if (rd || rw || wf) begin nx = 0; push = 1; rty = 1; end
      else if (kl) begin nx = 0; push = 1; end
    end
  endfunction

  function automatic string tag_of(input int tt, input bit ci, input bit q);
    if (!q) return "R2";
    if ((tt == 8 || tt == 9) && ci) return "R8";
    if (tt >= 8 && tt <= 11) return "R7";
    if (tt == 7) return "R9";
    if (tt == 6) return "R10";
    if (tt == 4 || tt == 5) return "R11";
    return "R12";
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset;
    // R1 reset state
    chk("R1", "line_state", line_state, 0);
    chk("R1", "bus_req", bus_req, 0);
    chk("R1", "snp_artry", snp_artry, 0);
    chk("R1", "req_ack", req_ack, 0);

    // R2, R7..R12 sweep over initial state, type, inhibit, qualification
    for (int s0 = 0; s0 < 3; s0++)
      for (int tt = 0; tt < 16; tt++)
        for (int ci = 0; ci < 2; ci++)
          for (int qv = 0; qv < 4; qv++) begin
            int nx; bit push, rty, q, canc;
            string rq;
            do_reset;
            if (s0 == 1) fill(A, 0, 0, 1);
            if (s0 == 2) fill(A, 0, 1, 0);
            q = (qv == 3);
            snp_ts = qv[0]; snp_gbl = qv[1]; snp_tt = tt[3:0]; snp_ci = ci[0]; snp_addr = A;
            step; snp_ts = 0; snp_gbl = 0;
            if (q) model(s0, tt, ci[0], nx, push, rty);
            else begin nx = s0; push = 0; rty = 0; end
            canc = q && (s0 == 1) && (tt == 6 || tt == 7 || nx == 0);
            rq = tag_of(tt, ci[0], q);
            chk(rq, "snp_artry", snp_artry, rty);
            chk(rq, "bus_req", bus_req, push);
            chk(rq, "resv_cancel", resv_cancel, canc);
            chk(rq, "state", ls(0), push ? s0 : nx);
            if (push) begin
              chk(rq, "bus_op", bus_op, 3);
              chk(rq, "bus_addr", bus_addr, A);
              push_done = 1; step; push_done = 0;
              chk(rq, "state after push", ls(0), nx);
            end
          end

    // R3 local hits
    do_reset; fill(A, 0, 0, 0);
    req_valid = 1; req_store = 0; req_addr = A; step; req_valid = 0;
    chk("R3", "load hit E ack", req_ack, 1); chk("R3", "load hit E bus", bus_req, 0);
    chk("R3", "load hit E state", ls(0), 1); step;
    req_valid = 1; req_store = 1; step; req_valid = 0;
    chk("R3", "store hit E ack", req_ack, 1); chk("R3", "store hit E state", ls(0), 2); step;
    req_valid = 1; req_store = 1; step; req_valid = 0;
    chk("R3", "store hit M ack", req_ack, 1); chk("R3", "store hit M state", ls(0), 2); step;
    req_valid = 1; req_store = 0; step; req_valid = 0;
    chk("R3", "load hit M ack", req_ack, 1); chk("R3", "load hit M bus", bus_req, 0); step;

    // R4 load miss with retry
    do_reset;
    req_valid = 1; req_store = 0; req_addr = C; req_way = 2; step;
    chk("R4", "bus_req", bus_req, 1); chk("R4", "bus_op", bus_op, 1);
    chk("R4", "bus_addr", bus_addr, C); chk("R4", "set_entry_vld", set_entry_vld, 1);
    chk("R4", "set_entry", set_entry, 2);
    bus_done = 1; bus_artry = 1; step;
    chk("R4", "reissue", bus_req, 1); chk("R4", "reissue op", bus_op, 1);
    chk("R4", "state I", ls(2), 0); chk("R4", "no ack", req_ack, 0);
    bus_artry = 0; step; bus_done = 0; req_valid = 0;
    chk("R4", "ack", req_ack, 1); chk("R4", "state E", ls(2), 1); step;

    // R5 store miss with retry
    do_reset;
    req_valid = 1; req_store = 1; req_addr = B; req_way = 3; step;
    chk("R5", "bus_op", bus_op, 2); chk("R5", "set_entry", set_entry, 3);
    bus_done = 1; bus_artry = 1; step;
    chk("R5", "reissue op", bus_op, 2); chk("R5", "state I", ls(3), 0);
    bus_artry = 0; step; bus_done = 0; req_valid = 0;
    chk("R5", "ack", req_ack, 1); chk("R5", "state M", ls(3), 2); step;

    // R6 cast-out of modified victim
    do_reset; fill(B, 1, 1, 0);
    req_valid = 1; req_store = 0; req_addr = C; req_way = 1; step;
    chk("R6", "push req", bus_req, 1); chk("R6", "push op", bus_op, 3);
    chk("R6", "push addr", bus_addr, B); chk("R6", "no set entry", set_entry_vld, 0);
    chk("R6", "victim still M", ls(1), 2);
    push_done = 1; step; push_done = 0;
    chk("R6", "victim I", ls(1), 0); chk("R6", "no req", bus_req, 0);
    step;
    chk("R6", "fill op", bus_op, 1); chk("R6", "fill addr", bus_addr, C);
    chk("R6", "fill entry", set_entry, 1);
    bus_done = 1; step; bus_done = 0; req_valid = 0;
    chk("R6", "ack", req_ack, 1); chk("R6", "state E", ls(1), 1); step;

    // R13 reservation
    do_reset; fill(A, 0, 0, 1);
    snoop(7, 0, A);
    chk("R13", "cancel on kill write", resv_cancel, 1); chk("R13", "line I", ls(0), 0);
    snoop(7, 0, A);
    chk("R13", "no second cancel", resv_cancel, 0);
    fill(A, 0, 0, 1);
    snoop(8, 1, A);
    chk("R13", "inhibited read keeps", resv_cancel, 0); chk("R13", "still E", ls(0), 1);
    snoop(6, 0, A);
    chk("R13", "cancel on kill block", resv_cancel, 1);
    fill(A, 0, 0, 0);
    snoop(8, 0, A);
    chk("R13", "plain load no resv", resv_cancel, 0);

    // R14 busy retry
    do_reset; fill(A, 0, 1, 0);
    req_valid = 1; req_store = 0; req_addr = B; req_way = 1; step;
    snoop(8, 0, A);
    chk("R14", "retry in fill", snp_artry, 1); chk("R14", "no push", bus_req, 0);
    chk("R14", "M kept", ls(0), 2);
    bus_done = 1; step; bus_done = 0; req_valid = 0;
    chk("R14", "fill done", ls(1), 1); step;
    snoop(8, 0, A);
    chk("R14", "push issued", bus_req, 1);
    snoop(7, 0, A);
    chk("R14", "retry on pushing line", snp_artry, 1); chk("R14", "still M", ls(0), 2);
    push_done = 1; step; push_done = 0;
    chk("R14", "pushed line I", ls(0), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule